// File: doc/BRIEF.md
# Loadable Four-Bit Sequence State Machine

This block is a synchronous state machine that holds its state in four D-type flip-flops and walks a fixed, non-contiguous ring of nine binary-coded states, one step per rising clock edge. The state bits are driven straight out of the block. A single flag output is decoded from them with combinational logic only. It is high in exactly one state of the ring.

A load strobe copies four external data bits into the state register on the next clock edge. This lets a test force any of the sixteen codes, whether the code is on the ring or not. The seven codes that are not on the ring are never left stranded: each of them has a fixed successor on the ring. So a forced or corrupted code rejoins the sequence after one clock. A synchronous reset puts the machine at the start of the ring.

Top module: `jam_seq_fsm`

## Requirements
- R1: The state is plain binary on `state_q`, with bit 0 as the least significant bit. `state_q` changes only on a rising edge of `clk`, and all four bits update together.
- R2: When neither reset nor load is active, the machine steps around the ring 5 → 7 → 8 → 9 → 11 → 12 → 13 → 3 → 4 and back to 5, one step per clock edge.
- R3: Each code off the ring moves to a fixed code on the ring at the next edge: 0→5, 1→7, 2→8, 6→7, 10→11, 14→4 and 15→5. No code off the ring ever leads to another code off the ring.
- R4: When `load_en` is high at a clock edge, `state_q` becomes `load_data` after that edge, bit for bit, with `load_data[0]` going to `state_q[0]`. All sixteen codes can be loaded this way.
- R5: The load takes priority over the ring and recovery logic. A load issued from any state ignores that state's normal successor.
- R6: `flag_out` is combinational from `state_q`. It is high exactly when `state_q` is 4'b1100 (12), and low for the other fifteen codes.
- R7: A synchronous active-high `rst` sets `state_q` to 5 at the next edge, and it overrides a simultaneous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, sets state 5 |
| load_en | input | 1 | Load strobe, copies `load_data` into the state at the next edge |
| load_data | input | 4 | Code to load, bit 0 is the least significant bit |
| state_q | output | 4 | Current state code |
| flag_out | output | 1 | High only in state 12 |

## Verification
Each change of the state register is due one clock edge after the inputs that caused it, whether that input is a load, a reset or the ring itself. `flag_out` follows the state within the same cycle, with no extra register. The bench drives its inputs on falling edges and compares at the next falling edge, so exactly one rising edge lies between a stimulus and its check. A loaded code is checked one edge after the load, and its successor one edge after that. The flag is checked against the same sampled state.

// File: rtl/jam_seq_pkg.sv
package jam_seq_pkg;

  localparam int unsigned SEQ_W     = 4;
  localparam int unsigned SEQ_CODES = 1 << SEQ_W;

  typedef logic [SEQ_W-1:0] seq_code_t;

  localparam seq_code_t HOME_CODE = seq_code_t'(5);
  localparam seq_code_t FLAG_CODE = seq_code_t'(12);

  // True when the code is one of the nine codes on the ring.
  function automatic logic on_ring(input seq_code_t c);
    case (c)
      4'd3, 4'd4, 4'd5, 4'd7, 4'd8, 4'd9, 4'd11, 4'd12, 4'd13: on_ring = 1'b1;
      default:                                                 on_ring = 1'b0;
    endcase
  endfunction

  // Successor of a code on the ring; codes off the ring give HOME_CODE here.
  function automatic seq_code_t ring_step(input seq_code_t c);
    case (c)
      4'd5:    ring_step = 4'd7;
      4'd7:    ring_step = 4'd8;
      4'd8:    ring_step = 4'd9;
      4'd9:    ring_step = 4'd11;
      4'd11:   ring_step = 4'd12;
      4'd12:   ring_step = 4'd13;
      4'd13:   ring_step = 4'd3;
      4'd3:    ring_step = 4'd4;
      4'd4:    ring_step = 4'd5;
      default: ring_step = HOME_CODE;
    endcase
  endfunction

  // Recovery target for a code off the ring; codes on the ring give HOME_CODE here.
  function automatic seq_code_t rescue_step(input seq_code_t c);
    case (c)
      4'd0:    rescue_step = 4'd5;
      4'd1:    rescue_step = 4'd7;
      4'd2:    rescue_step = 4'd8;
      4'd6:    rescue_step = 4'd7;
      4'd10:   rescue_step = 4'd11;
      4'd14:   rescue_step = 4'd4;
      4'd15:   rescue_step = 4'd5;
      default: rescue_step = HOME_CODE;
    endcase
  endfunction

endpackage

// File: rtl/jam_seq_next.sv
module jam_seq_next
  import jam_seq_pkg::*;
(
  input  seq_code_t cur_code,
  output seq_code_t nxt_code,
  output logic      cur_on_ring
);

  seq_code_t step_code;
  seq_code_t rescue_code;

  always_comb begin
    cur_on_ring = on_ring(cur_code);
    step_code   = ring_step(cur_code);
    rescue_code = rescue_step(cur_code);
    nxt_code    = cur_on_ring ? step_code : rescue_code;
  end

  // R3: whatever the current code, the computed successor lies on the ring
  always_comb begin
    a_r3_next_on_ring: assert (on_ring(nxt_code) || $isunknown(cur_code));
  end

endmodule

// File: rtl/jam_seq_decode.sv
module jam_seq_decode
  import jam_seq_pkg::*;
#(
  parameter seq_code_t MATCH = FLAG_CODE
) (
  input  seq_code_t code_in,
  output logic      hit
);

  logic [SEQ_W-1:0] bit_eq;

  for (genvar b = 0; b < SEQ_W; b++) begin : g_bit
    assign bit_eq[b] = ~(code_in[b] ^ MATCH[b]);
  end

  assign hit = &bit_eq;

endmodule

// File: rtl/jam_seq_reg.sv
module jam_seq_reg
  import jam_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_en,
  input  seq_code_t load_code,
  input  seq_code_t auto_code,
  output seq_code_t q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= HOME_CODE;
    else if (load_en) q <= load_code;
    else              q <= auto_code;
  end

endmodule

// File: rtl/jam_seq_fsm.sv
module jam_seq_fsm
  import jam_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [SEQ_W-1:0] load_data,
  output logic [SEQ_W-1:0] state_q,
  output logic             flag_out
);

  seq_code_t auto_code;
  logic      was_on_ring;
  logic      past_ok = 1'b0;

  jam_seq_next u_next (
    .cur_code    (state_q),
    .nxt_code    (auto_code),
    .cur_on_ring (was_on_ring)
  );

  jam_seq_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_code (load_data),
    .auto_code (auto_code),
    .q         (state_q)
  );

  jam_seq_decode #(.MATCH(FLAG_CODE)) u_dec (
    .code_in (state_q),
    .hit     (flag_out)
  );

  always_ff @(posedge clk) past_ok <= 1'b1;

  // R7: reset lands on the home code, even with a load pending
  a_r7_reset_home: assert property (@(posedge clk)
    past_ok && $past(rst) |-> state_q == HOME_CODE);

  // R4, R5: a load wins over the ring and recovery logic
  a_r4_load_copies: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(load_en) |-> state_q == $past(load_data));

  // R2: a code on the ring advances to its successor
  a_r2_ring_step: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(load_en) && $past(was_on_ring)
      |-> state_q == ring_step($past(state_q)));

  // R3: a code off the ring rejoins the ring in one step
  a_r3_rejoin: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(load_en) && !$past(was_on_ring)
      |-> on_ring(state_q));

  // R6: the flag marks state 12 and nothing else
  a_r6_flag_only_12: assert property (@(posedge clk) disable iff (rst)
    flag_out |-> state_q == 4'b1100);

endmodule

// File: tb/jam_seq_fsm_bench.sv
module jam_seq_fsm_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       load_en;
  logic [3:0] load_data;
  logic [3:0] state_q;
  logic       flag_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  jam_seq_fsm u_jam_seq_fsm (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_data (load_data),
    .state_q   (state_q),
    .flag_out  (flag_out)
  );

  // Bench model: ring as an ordered list, recovery as pairs.
  int ring [9] = '{5, 7, 8, 9, 11, 12, 13, 3, 4};
  int lost [7] = '{0, 1, 2, 6, 10, 14, 15};
  int home [7] = '{5, 7, 8, 7, 11, 4, 5};

  function automatic int expect_next(input int c);
    for (int i = 0; i < 9; i++) if (ring[i] == c) return ring[(i + 1) % 9];
    for (int i = 0; i < 7; i++) if (lost[i] == c) return home[i];
    return -1;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; load_en = 1'b0; load_data = 4'd0;
    tick(); tick();
    check("R7 reset state", state_q, 5);
    check("R6 flag in reset state", flag_out, 0);
    rst = 1'b0;
  endtask

  task automatic t_load_all();
    for (int c = 0; c < 16; c++) begin
      load_en = 1'b1; load_data = 4'(c);
      tick();
      load_en = 1'b0;
      check("R4 loaded code", state_q, c);
      check("R1 bit0 after load", state_q[0], c % 2);
      check("R6 flag of loaded code", flag_out, (c == 12) ? 1 : 0);
      tick();
      if (c == 3 || c == 4 || c == 5 || c == 7 || c == 8 || c == 9 ||
          c == 11 || c == 12 || c == 13)
        check("R2 successor of ring code", state_q, expect_next(c));
      else
        check("R3 recovery of lost code", state_q, expect_next(c));
    end
  endtask

  task automatic t_ring_twice();
    rst = 1'b1; tick(); rst = 1'b0;
    check("R7 ring start", state_q, 5);
    for (int lap = 0; lap < 2; lap++) begin
      for (int i = 0; i < 9; i++) begin
        check("R2 ring position", state_q, ring[i]);
        check("R6 flag on ring", flag_out, (ring[i] == 12) ? 1 : 0);
        tick();
      end
    end
    check("R2 back home after two laps", state_q, 5);
  endtask

  task automatic t_load_priority();
    rst = 1'b1; tick(); rst = 1'b0;
    tick();
    check("R2 step before override", state_q, 7);
    load_en = 1'b1; load_data = 4'd14;
    tick();
    load_en = 1'b0;
    check("R5 load beats normal successor", state_q, 14);
    tick();
    check("R3 14 recovers to 4", state_q, 4);
  endtask

  task automatic t_reset_over_load();
    load_en = 1'b1; load_data = 4'd12; rst = 1'b1;
    tick();
    rst = 1'b0; load_en = 1'b0;
    check("R7 reset beats load", state_q, 5);
    check("R6 flag low after reset", flag_out, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load_all();
        t_ring_twice();
        t_load_priority();
        t_reset_over_load();
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule